// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block serves one phase of a synchronous buck stage. It turns a single PWM command into two gate enables, one for the high-side switch and one for the low-side switch. Its rule is that one switch is never turned on until the other is seen to be off. When the command falls, the high-side enable drops first. The low-side enable follows only after a comparator reports that the switch node has fallen, and then a programmable settling delay has passed. When the command rises, the low-side enable drops first. The high-side enable follows only after a comparator reports that the low-side gate has discharged, and then the same delay has passed.

Under reverse inductor current the switch node may never fall. A watchdog handles this case: it turns the low side on anyway after a programmable number of cycles, so that the current can recirculate. Two inputs from the protection logic override the PWM command. One holds the low side on with the high side off. The other holds both switches off. A PWM edge that arrives while a turn-on is still pending cancels that turn-on and starts the opposite sequence at once. All delays are given in clock cycles.

Top module: `dt_gate_ctrl`

## Requirements
- R1: While `rst_ni` is low both enables are 0. After reset the sequencer starts from a both-off state. From there, PWM low starts the low-side sequence (R2/R4) and PWM high starts the high-side sequence (R3).
- R2: When `pwm_i` is sampled low, `hs_en_o` is 0 from the next cycle. `ls_en_o` rises only after `node_low_i` is sampled 1 while waiting. It rises exactly DLY_CYC cycles after the edge that sampled the flag.
- R3: When `pwm_i` is sampled high, `ls_en_o` is 0 from the next cycle. `hs_en_o` rises only after `lgate_low_i` is sampled 1 while waiting. It rises exactly DLY_CYC cycles after the edge that sampled the flag.
- R4: The switch-node wait can last at most WDOG_CYC cycles. If `node_low_i` is never seen in that time, `ls_en_o` rises on the following edge without the settling delay.
- R5: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R6: `force_ls_i`=1 clears `hs_en_o` in the same cycle. It drives `ls_en_o` to 1 from the next edge and keeps it there, whatever the value of `pwm_i`. Once the input is released, the R2/R3 sequences resume.
- R7: `disable_i`=1 clears both enables in the same cycle and holds them at 0. It takes priority over `force_ls_i`.
- R8: A change of `pwm_i` during a flag wait or a settling delay cancels the pending turn-on. The opposite sequence then starts with fresh timing.
- R9: A flag sampled outside its own waiting phase has no effect. This covers `node_low_i` while the high side is on or pending, and `lgate_low_i` while the low side is on or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Phase PWM command, 1 = high side on |
| node_low_i | input | 1 | Comparator: switch node below its threshold |
| lgate_low_i | input | 1 | Comparator: low-side gate below its threshold |
| force_ls_i | input | 1 | Protection override: low side on, high side off |
| disable_i | input | 1 | Protection override: both switches off |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
Assertions check properties on every cycle. They check that the two enables are mutually exclusive and that the overrides act in the same cycle or on the next edge. They check that each enable drops one edge after the matching PWM level. They also check that the high side is only entered through its settling delay and that the switch-node wait is only left early on the flag. The exact cycle counts of the settling delay and the watchdog are left to the bench's cycle-accurate reference model, as are the abort paths when PWM toggles mid-sequence and the flags being ignored in the wrong phase. A long pseudo-random run with mixed overrides exercises the interactions that the directed scenarios do not reach.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_HS_ON,
    ST_WAIT_NODE,
    ST_DLY_LS,
    ST_LS_ON,
    ST_WAIT_LGATE,
    ST_DLY_HS
  } dt_state_e;
endpackage

// File: rtl/dt_timer.sv
module dt_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
endmodule

// File: rtl/dt_fsm.sv
module dt_fsm
  import dt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic node_low_i,
  input  logic lgate_low_i,
  input  logic force_ls_i,
  input  logic disable_i,
  input  logic dly_zero_i,
  input  logic wd_zero_i,
  output logic dly_load_o,
  output logic wd_load_o,
  output logic hs_state_o,
  output logic ls_state_o
);
  dt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (disable_i)       st_d = ST_OFF;
    else if (force_ls_i) st_d = ST_LS_ON;
    else begin
      unique case (st_q)
        ST_OFF:        st_d = pwm_i ? ST_WAIT_LGATE : ST_WAIT_NODE;
        ST_HS_ON:      if (!pwm_i) st_d = ST_WAIT_NODE;
        ST_WAIT_NODE: begin
          if (pwm_i)           st_d = ST_WAIT_LGATE;
          else if (node_low_i) st_d = ST_DLY_LS;
          else if (wd_zero_i)  st_d = ST_LS_ON;   // reverse current: no node fall
        end
        ST_DLY_LS: begin
          if (pwm_i)           st_d = ST_WAIT_LGATE;
          else if (dly_zero_i) st_d = ST_LS_ON;
        end
        ST_LS_ON:      if (pwm_i) st_d = ST_WAIT_LGATE;
        ST_WAIT_LGATE: begin
          if (!pwm_i)           st_d = ST_WAIT_NODE;
          else if (lgate_low_i) st_d = ST_DLY_HS;
        end
        ST_DLY_HS: begin
          if (!pwm_i)          st_d = ST_WAIT_NODE;
          else if (dly_zero_i) st_d = ST_HS_ON;
        end
        default:       st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign dly_load_o = (st_d != st_q) && (st_d == ST_DLY_LS || st_d == ST_DLY_HS);
  assign wd_load_o  = (st_d != st_q) && (st_d == ST_WAIT_NODE);
  assign hs_state_o = (st_q == ST_HS_ON);
  assign ls_state_o = (st_q == ST_LS_ON);

  p_hs_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !hs_state_o);
  p_ls_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !force_ls_i) |=> !ls_state_o);
  p_hs_via_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_state_o) |-> $past(st_q) == ST_DLY_HS);
  p_dly_ls_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_DLY_LS) |-> $past(node_low_i));
  p_wd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_NODE && !pwm_i && !node_low_i && !force_ls_i && !disable_i && !wd_zero_i)
      |=> st_q == ST_WAIT_NODE);
  p_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_ls_i && !disable_i) |=> ls_state_o);
endmodule

// File: rtl/dt_gate_out.sv
module dt_gate_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_state_i,
  input  logic ls_state_i,
  input  logic force_ls_i,
  input  logic disable_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  // overrides act combinationally so protection needs no clock edge to cut the high side
  assign hs_en_o = hs_state_i && !force_ls_i && !disable_i;
  assign ls_en_o = ls_state_i && !disable_i;

  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));
  p_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |-> (!hs_en_o && !ls_en_o));
  p_force_hs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ls_i |-> !hs_en_o);
endmodule

// File: rtl/dt_gate_ctrl.sv
module dt_gate_ctrl #(
  parameter int DLY_CYC  = 3,
  parameter int WDOG_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic node_low_i,
  input  logic lgate_low_i,
  input  logic force_ls_i,
  input  logic disable_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int MAXC = (DLY_CYC > WDOG_CYC) ? DLY_CYC : WDOG_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LD = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] WD_LD  = CW'(WDOG_CYC - 1);

  logic dly_load, wd_load, dly_zero, wd_zero, hs_state, ls_state;

  dt_fsm u_fsm (
    .clk_i, .rst_ni, .pwm_i, .node_low_i, .lgate_low_i, .force_ls_i, .disable_i,
    .dly_zero_i(dly_zero), .wd_zero_i(wd_zero),
    .dly_load_o(dly_load), .wd_load_o(wd_load),
    .hs_state_o(hs_state), .ls_state_o(ls_state)
  );

  dt_timer #(.W(CW)) u_dly (
    .clk_i, .rst_ni, .load_i(dly_load), .val_i(DLY_LD), .zero_o(dly_zero)
  );

  dt_timer #(.W(CW)) u_wd (
    .clk_i, .rst_ni, .load_i(wd_load), .val_i(WD_LD), .zero_o(wd_zero)
  );

  dt_gate_out u_out (
    .clk_i, .rst_ni, .hs_state_i(hs_state), .ls_state_i(ls_state),
    .force_ls_i, .disable_i, .hs_en_o, .ls_en_o
  );

  initial begin
    assert (DLY_CYC >= 1 && WDOG_CYC >= 1);
  end
endmodule

// File: tb/dt_gate_ctrl_bench.sv
module dt_gate_ctrl_bench;
  localparam int DLY = 3;
  localparam int WD  = 24;
  localparam int M_OFF = 0, M_HS = 1, M_WN = 2, M_DL = 3, M_LS = 4, M_WL = 5, M_DH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, node_low = 1'b0, lgate_low = 1'b0, force_ls = 1'b0, dis = 1'b0;
  logic hs_en, ls_en;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int mode = M_OFF;
  int elapsed = 0;

  always #10 clk = ~clk;

  dt_gate_ctrl #(.DLY_CYC(DLY), .WDOG_CYC(WD)) u_dt_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .node_low_i(node_low),
    .lgate_low_i(lgate_low), .force_ls_i(force_ls), .disable_i(dis),
    .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  // behavioural reference: phase plus elapsed cycles in that phase
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = M_OFF; elapsed = 0;
    end else if (dis) begin
      mode = M_OFF;
    end else if (force_ls) begin
      mode = M_LS;
    end else begin
      case (mode)
        M_OFF: if (pwm) mode = M_WL; else begin mode = M_WN; elapsed = 0; end
        M_HS:  if (!pwm) begin mode = M_WN; elapsed = 0; end
        M_WN: begin
          if (pwm) mode = M_WL;
          else if (node_low) begin mode = M_DL; elapsed = 0; end
          else if (elapsed == WD - 1) mode = M_LS;
          else elapsed++;
        end
        M_DL: begin
          if (pwm) mode = M_WL;
          else if (elapsed == DLY - 1) mode = M_LS;
          else elapsed++;
        end
        M_LS:  if (pwm) mode = M_WL;
        M_WL: begin
          if (!pwm) begin mode = M_WN; elapsed = 0; end
          else if (lgate_low) begin mode = M_DH; elapsed = 0; end
        end
        M_DH: begin
          if (!pwm) begin mode = M_WN; elapsed = 0; end
          else if (elapsed == DLY - 1) mode = M_HS;
          else elapsed++;
        end
        default: mode = M_OFF;
      endcase
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(hs_en, (mode == M_HS) && !force_ls && !dis && rst_n, "hs_en_o");
      check(ls_en, (mode == M_LS) && !dis && rst_n, "ls_en_o");
      check(hs_en && ls_en, 1'b0, "R5 exclusive");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cur_req = "R1"; cyc(3);
    rst_n = 1'b1;
    cur_req = "R4"; cyc(WD + 4);                     // node never falls
    cur_req = "R3"; pwm = 1'b1; cyc(4);
    lgate_low = 1'b1; cyc(DLY + 3);
    cur_req = "R9"; node_low = 1'b1; cyc(4);         // node flag while high side on
    lgate_low = 1'b0; node_low = 1'b0;
    cur_req = "R2"; pwm = 1'b0; cyc(3);
    node_low = 1'b1; cyc(1); node_low = 1'b0; cyc(DLY + 3);
    cur_req = "R9"; lgate_low = 1'b1; cyc(3);        // gate flag while low side on
    cur_req = "R8"; pwm = 1'b1; cyc(2);              // into delay, then abort
    pwm = 1'b0; lgate_low = 1'b0; cyc(2);
    pwm = 1'b1; cyc(2); pwm = 1'b0; node_low = 1'b1; cyc(1);
    pwm = 1'b1; node_low = 1'b0; cyc(2); lgate_low = 1'b1; cyc(DLY + 2);
    cur_req = "R6"; force_ls = 1'b1; cyc(3);
    pwm = 1'b0; cyc(2); pwm = 1'b1; cyc(2);
    force_ls = 1'b0; cyc(DLY + 4);
    cur_req = "R7"; dis = 1'b1; cyc(3);
    force_ls = 1'b1; cyc(2);
    dis = 1'b0; cyc(2); force_ls = 1'b0; cyc(DLY + 4);
    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      pwm       = (($urandom % 16) < 8) ? ~pwm : pwm;
      node_low  = ($urandom % 4) == 0;
      lgate_low = ($urandom % 3) == 0;
      force_ls  = ($urandom % 64) == 0;
      dis       = ($urandom % 80) == 0;
      if (k % 200 < 40) node_low = 1'b0;           // let the watchdog expire sometimes
      if (k % 200 < 40) pwm = 1'b0;
      cyc(1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule